// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides, without any clock or state, whether the instruction being examined should take effect. It reads a four-bit condition selector from the opcode and tests it against four arithmetic flags held in the top nibble of a status word. The flags are negative, zero, carry and overflow. A pass bit comes out, together with the address of the next sequential instruction. A sequencer uses that address as the next PC when the pass bit is low.

The unit serves two instruction widths. With 32-bit encodings, the selector sits in the top four opcode bits and gates every instruction. With 16-bit encodings, only a conditional branch can be suppressed. Such a branch is recognised by a fixed four-bit prefix in opcode bits 15..12, and its selector lies in opcode bits 11..8. Every other 16-bit instruction passes. The sequential address advances by the width of the current encoding.

Parameters set the data and PC widths, where the fields sit, the branch prefix and the step sizes. A further parameter picks one of two implementations of the flag table: a direct sixteen-way case, or a shared eight-entry base whose result is inverted by the selector's low bit.

Top module: `cc_gate_eval`

## Requirements
- R1: Flags come from the status word as V at bit 28, C at bit 29, Z at bit 30 and N at bit 31. Selectors 0..7 each test one flag: 0 passes if Z=1, 1 if Z=0, 2 if C=1, 3 if C=0, 4 if N=1, 5 if N=0, 6 if V=1, 7 if V=0.
- R2: Selector 8 passes when C=1 and Z=0. Selector 9 passes when C=0 or Z=1.
- R3: Selector 10 passes when N equals V. Selector 11 passes when N differs from V.
- R4: Selector 12 passes when Z=0 and N equals V. Selector 13 passes when Z=1 or N differs from V.
- R5: Selectors 14 and 15 pass for every flag value.
- R6: With `narrow_mode_i`=0, the selector is opcode bits 31..28 and applies to every opcode. Opcode bits 11..8 have no effect.
- R7: With `narrow_mode_i`=1, the selector is opcode bits 11..8. It applies only when opcode bits 15..12 equal 4'b1101. Otherwise `exec_o`=1 whatever the flags are, and opcode bits 31..28 never have an effect.
- R8: `skip_pc_o` equals `pc_i`+4 when `narrow_mode_i`=0 and `pc_i`+2 when `narrow_mode_i`=1, wrapping modulo 2^32.
- R9: Both outputs are a pure function of the current inputs and settle in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 32 | Instruction word; a 16-bit encoding occupies bits 15..0 |
| status_i | input | 32 | Status word holding the N, Z, C and V flags in bits 31..28 |
| pc_i | input | 32 | Address of the instruction being examined |
| narrow_mode_i | input | 1 | 1 selects 16-bit instruction state, 0 selects 32-bit state |
| exec_o | output | 1 | 1 when the instruction is to take effect |
| skip_pc_o | output | 32 | Next sequential address, used when `exec_o` is 0 |

## Verification
The bench sweeps all sixteen selectors against all sixteen flag patterns in both states. A design that swapped two flag positions, or left out the inversion between paired selectors, would produce the wrong pass bit for part of each sweep. In 16-bit state the bench also places conflicting selectors in the unused opcode fields and sends non-branch prefixes. A selector taken from the wrong field would therefore gate by the wrong condition, and a non-branch opcode could be suppressed. The address is checked at the top of the address space, which exposes a wrong step size or a carry that does not wrap.

// File: rtl/cc_eval_pkg.sv
package cc_eval_pkg;

   typedef enum logic [3:0] {
      CC_ZSET    = 4'd0,
      CC_ZCLR    = 4'd1,
      CC_CSET    = 4'd2,
      CC_CCLR    = 4'd3,
      CC_NSET    = 4'd4,
      CC_NCLR    = 4'd5,
      CC_VSET    = 4'd6,
      CC_VCLR    = 4'd7,
      CC_UHIGHER = 4'd8,
      CC_ULOWSM  = 4'd9,
      CC_SGE     = 4'd10,
      CC_SLT     = 4'd11,
      CC_SGT     = 4'd12,
      CC_SLE     = 4'd13,
      CC_ALWAYS  = 4'd14,
      CC_ALWAYS2 = 4'd15
   } cond_code_e;

   typedef struct packed {
      logic neg;
      logic zero;
      logic carry;
      logic ovf;
   } flags_t;

   localparam int TABLE_CASE   = 0;
   localparam int TABLE_PAIRED = 1;

endpackage

// File: rtl/cc_cond_select.sv
module cc_cond_select
   import cc_eval_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int WIDE_LSB     = 28,
   parameter int NARROW_LSB   = 8,
   parameter int PREFIX_LSB   = 12,
   parameter logic [3:0] BR_PREFIX = 4'b1101
) (
   input  logic [WORD_W-1:0] opcode_i,
   input  logic              narrow_i,
   output cond_code_e        cond_o,
   output logic              gated_o
);

   logic [3:0] wide_field;
   logic [3:0] narrow_field;
   logic       is_branch;
   logic       unused_opcode;

   assign wide_field    = opcode_i[WIDE_LSB +: 4];
   assign narrow_field  = opcode_i[NARROW_LSB +: 4];
   assign is_branch     = (opcode_i[PREFIX_LSB +: 4] == BR_PREFIX);
   assign unused_opcode = ^opcode_i;

   always_comb begin
      if (narrow_i) begin
         cond_o  = cond_code_e'(narrow_field);
         gated_o = is_branch;
      end else begin
         cond_o  = cond_code_e'(wide_field);
         gated_o = 1'b1;
      end
   end

endmodule

// File: rtl/cc_flag_table.sv
module cc_flag_table
   import cc_eval_pkg::*;
#(
   parameter int TABLE_STYLE = TABLE_CASE
) (
   input  cond_code_e cond_i,
   input  flags_t     flags_i,
   output logic       pass_o
);

   logic n_eq_v;
   assign n_eq_v = (flags_i.neg == flags_i.ovf);

   generate
      if (TABLE_STYLE == TABLE_CASE) begin : g_case
         always_comb begin
            unique case (cond_i)
               CC_ZSET:    pass_o = flags_i.zero;
               CC_ZCLR:    pass_o = !flags_i.zero;
               CC_CSET:    pass_o = flags_i.carry;
               CC_CCLR:    pass_o = !flags_i.carry;
               CC_NSET:    pass_o = flags_i.neg;
               CC_NCLR:    pass_o = !flags_i.neg;
               CC_VSET:    pass_o = flags_i.ovf;
               CC_VCLR:    pass_o = !flags_i.ovf;
               CC_UHIGHER: pass_o = flags_i.carry && !flags_i.zero;
               CC_ULOWSM:  pass_o = !flags_i.carry || flags_i.zero;
               CC_SGE:     pass_o = n_eq_v;
               CC_SLT:     pass_o = !n_eq_v;
               CC_SGT:     pass_o = !flags_i.zero && n_eq_v;
               CC_SLE:     pass_o = flags_i.zero || !n_eq_v;
               default:    pass_o = 1'b1;
            endcase
         end
      end else begin : g_paired
         logic [2:0] pair_idx;
         logic       base;
         assign pair_idx = cond_i[3:1];
         always_comb begin
            case (pair_idx)
               3'd0:    base = flags_i.zero;
               3'd1:    base = flags_i.carry;
               3'd2:    base = flags_i.neg;
               3'd3:    base = flags_i.ovf;
               3'd4:    base = flags_i.carry && !flags_i.zero;
               3'd5:    base = n_eq_v;
               3'd6:    base = !flags_i.zero && n_eq_v;
               default: base = 1'b1;
            endcase
            if (pair_idx == 3'd7) pass_o = 1'b1;
            else                  pass_o = base ^ cond_i[0];
         end
      end
   endgenerate

   // Guards on the signed and unsigned combinations.
   always_comb begin
      if (cond_i == CC_SGT && flags_i.zero)
         assert_gt_blocked_by_zero_R4: assert (!pass_o);
      if (cond_i == CC_SGE && (flags_i.neg != flags_i.ovf))
         assert_ge_sign_mismatch_R3: assert (!pass_o);
      if (cond_i == CC_UHIGHER && !flags_i.carry)
         assert_hi_needs_carry_R2: assert (!pass_o);
   end

endmodule

// File: rtl/cc_pc_step.sv
module cc_pc_step #(
   parameter int PC_W        = 32,
   parameter int WIDE_STEP   = 4,
   parameter int NARROW_STEP = 2
) (
   input  logic [PC_W-1:0] pc_i,
   input  logic            narrow_i,
   output logic [PC_W-1:0] skip_pc_o
);

   localparam logic [PC_W-1:0] WIDE_INC   = PC_W'(WIDE_STEP);
   localparam logic [PC_W-1:0] NARROW_INC = PC_W'(NARROW_STEP);

   logic [PC_W-1:0] inc;
   assign inc       = narrow_i ? NARROW_INC : WIDE_INC;
   assign skip_pc_o = pc_i + inc;

endmodule

// File: rtl/cc_gate_eval.sv
module cc_gate_eval
   import cc_eval_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int PC_W        = 32,
   parameter int FLAG_MSB    = 31,
   parameter int WIDE_LSB    = 28,
   parameter int NARROW_LSB  = 8,
   parameter int PREFIX_LSB  = 12,
   parameter logic [3:0] BR_PREFIX = 4'b1101,
   parameter int WIDE_STEP   = 4,
   parameter int NARROW_STEP = 2,
   parameter int TABLE_STYLE = TABLE_CASE
) (
   input  logic [WORD_W-1:0] opcode_i,
   input  logic [WORD_W-1:0] status_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic              narrow_mode_i,
   output logic              exec_o,
   output logic [PC_W-1:0]   skip_pc_o
);

   localparam int FLAG_LSB = FLAG_MSB - 3;

   generate
      if (FLAG_LSB < 0 || FLAG_MSB >= WORD_W) begin : g_bad_flags
         $error("cc_gate_eval: flag nibble outside status word");
      end
      if (WIDE_LSB + 3 >= WORD_W || NARROW_LSB + 3 >= WORD_W ||
          PREFIX_LSB + 3 >= WORD_W) begin : g_bad_fields
         $error("cc_gate_eval: condition field outside opcode");
      end
      if (TABLE_STYLE != TABLE_CASE && TABLE_STYLE != TABLE_PAIRED) begin : g_bad_style
         $error("cc_gate_eval: unknown table style");
      end
      if (WIDE_STEP <= 0 || NARROW_STEP <= 0 || (WIDE_STEP % 2) != 0 ||
          (NARROW_STEP % 2) != 0) begin : g_bad_step
         $error("cc_gate_eval: steps must be positive and even");
      end
   endgenerate

   flags_t     flags;
   cond_code_e cond;
   logic       gated;
   logic       table_pass;
   logic       unused_status;

   assign flags         = flags_t'(status_i[FLAG_LSB +: 4]);
   assign unused_status = ^status_i;

   cc_cond_select #(
      .WORD_W     (WORD_W),
      .WIDE_LSB   (WIDE_LSB),
      .NARROW_LSB (NARROW_LSB),
      .PREFIX_LSB (PREFIX_LSB),
      .BR_PREFIX  (BR_PREFIX)
   ) sel_i (
      .opcode_i (opcode_i),
      .narrow_i (narrow_mode_i),
      .cond_o   (cond),
      .gated_o  (gated)
   );

   cc_flag_table #(
      .TABLE_STYLE (TABLE_STYLE)
   ) tbl_i (
      .cond_i  (cond),
      .flags_i (flags),
      .pass_o  (table_pass)
   );

   cc_pc_step #(
      .PC_W        (PC_W),
      .WIDE_STEP   (WIDE_STEP),
      .NARROW_STEP (NARROW_STEP)
   ) step_i (
      .pc_i      (pc_i),
      .narrow_i  (narrow_mode_i),
      .skip_pc_o (skip_pc_o)
   );

   assign exec_o = !gated || table_pass;

   always_comb begin
      if (cond == CC_ALWAYS || cond == CC_ALWAYS2)
         assert_always_codes_pass_R5: assert (exec_o);
      if (!narrow_mode_i)
         assert_wide_always_gated_R6: assert (gated);
      if (narrow_mode_i && opcode_i[PREFIX_LSB +: 4] != BR_PREFIX)
         assert_narrow_nonbranch_runs_R7: assert (exec_o);
      assert_skip_keeps_parity_R8: assert (skip_pc_o[0] == pc_i[0]);
      assert_skip_moves_R8: assert (skip_pc_o != pc_i);
   end

endmodule

// File: tb/cc_gate_eval_tb_top.sv
module cc_gate_eval_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opcode = '0;
   logic [31:0] status = '0;
   logic [31:0] pc = '0;
   logic        narrow = 1'b0;
   logic        exec_w;
   logic [31:0] skip_w;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   cc_gate_eval dut_i (
      .opcode_i      (opcode),
      .status_i      (status),
      .pc_i          (pc),
      .narrow_mode_i (narrow),
      .exec_o        (exec_w),
      .skip_pc_o     (skip_w)
   );

   // Behavioural reference: flags by name, selector by explicit meaning.
   function automatic bit model_table(int sel, logic [31:0] st);
      bit n = st[31];
      bit z = st[30];
      bit c = st[29];
      bit v = st[28];
      bit res;
      if      (sel == 0)  res = z;
      else if (sel == 1)  res = !z;
      else if (sel == 2)  res = c;
      else if (sel == 3)  res = !c;
      else if (sel == 4)  res = n;
      else if (sel == 5)  res = !n;
      else if (sel == 6)  res = v;
      else if (sel == 7)  res = !v;
      else if (sel == 8)  res = c && !z;
      else if (sel == 9)  res = !c || z;
      else if (sel == 10) res = (n == v);
      else if (sel == 11) res = (n != v);
      else if (sel == 12) res = !z && (n == v);
      else if (sel == 13) res = z || (n != v);
      else                res = 1'b1;
      return res;
   endfunction

   function automatic bit model_exec(logic [31:0] op, logic [31:0] st, bit nar);
      if (!nar) return model_table(int'(op[31:28]), st);
      if (op[15:12] != 4'b1101) return 1'b1;
      return model_table(int'(op[11:8]), st);
   endfunction

   function automatic logic [31:0] model_skip(logic [31:0] p, bit nar);
      return nar ? p + 32'd2 : p + 32'd4;
   endfunction

   function automatic string table_tag(int sel);
      if (sel < 8)  return "R1";
      if (sel < 10) return "R2";
      if (sel < 12) return "R3";
      if (sel < 14) return "R4";
      return "R5";
   endfunction

   task automatic apply_and_check(input logic [31:0] op, input logic [31:0] st,
                                  input logic [31:0] p, input bit nar,
                                  input string tag);
      bit          exp_e;
      logic [31:0] exp_pc;
      @(negedge clk);
      opcode = op;
      status = st;
      pc     = p;
      narrow = nar;
      exp_e  = model_exec(op, st, nar);
      exp_pc = model_skip(p, nar);
      #2;
      checks++;
      if (exec_w !== exp_e) begin
         errors++;
         $display("FAIL %s exec op=%h st=%h nar=%0d actual=%0b expected=%0b",
                  tag, op, st, nar, exec_w, exp_e);
      end
      checks++;
      if (skip_w !== exp_pc) begin
         errors++;
         $display("FAIL R8 skip pc=%h nar=%0d actual=%h expected=%h",
                  p, nar, skip_w, exp_pc);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Initial state, same-cycle response (R9): all-zero inputs -> selector 0, Z=0
      apply_and_check(32'h0, 32'h0, 32'h0, 1'b0, "R9");

      // R1..R5: full flag table in 32-bit state
      for (int sel = 0; sel < 16; sel++) begin
         for (int f = 0; f < 16; f++) begin
            apply_and_check({sel[3:0], 28'h0A5_5A3C}, {f[3:0], 28'h123_4567},
                            32'h1000 + 32'(sel * 64 + f * 4), 1'b0, table_tag(sel));
         end
      end

      // R6: bits 11..8 hold a conflicting selector in 32-bit state
      apply_and_check(32'h0000_D100, 32'h4000_0000, 32'h2000, 1'b0, "R6");
      apply_and_check(32'h1000_D000, 32'h0000_0000, 32'h2004, 1'b0, "R6");
      apply_and_check(32'hB000_DE00, 32'h8000_0000, 32'h2008, 1'b0, "R6");

      // R7: 16-bit branch, junk in bits 31..28
      for (int sel = 0; sel < 16; sel++) begin
         for (int f = 0; f < 16; f++) begin
            apply_and_check({4'(15 - sel), 12'h3C5, 4'b1101, sel[3:0], 8'h7E},
                            {f[3:0], 28'h0},
                            32'h4000 + 32'(sel * 32 + f * 2), 1'b1, "R7");
         end
      end

      // R7: 16-bit non-branch prefixes ignore flags and selector fields
      for (int pre = 0; pre < 16; pre++) begin
         if (pre != 13) begin
            for (int f = 0; f < 16; f++) begin
               apply_and_check({4'h0, 12'h0, pre[3:0], 4'h1, 8'h00},
                               {f[3:0], 28'hFFF_FFFF}, 32'h6000, 1'b1, "R7");
            end
         end
      end

      // R8: wrap at the top of the address space
      apply_and_check(32'h0000_0000, 32'h0, 32'hFFFF_FFFC, 1'b0, "R8");
      apply_and_check(32'h0000_0000, 32'h0, 32'hFFFF_FFFE, 1'b1, "R8");
      apply_and_check(32'h0000_0000, 32'h0, 32'hFFFF_FFFE, 1'b0, "R8");
      apply_and_check(32'h0000_0000, 32'h0, 32'h7FFF_FFFE, 1'b1, "R8");

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule